// File: doc/BRIEF.md
# Serial Audio Transmitter with Packed Sample Queue

This block turns audio samples written by a host into a serial stream made of a bit clock, a word-select line and a data line. The host pushes 32-bit words into an eight-deep queue. A packing mode selects how each word is read. A word can hold a single channel sample, one sample for both channels, or a left/right pair packed as two 16-bit or two 8-bit halves. The transmitter unpacks the samples at the channel boundaries. It shifts them out MSB first in one of three framing styles: I2S, left-justified or right-justified.

Each channel occupies a half-frame of 32 bit clocks. In master mode the block divides the system clock to make the bit clock and drives word-select. In slave mode it synchronises an external bit clock and word-select and follows their edges. When the queue is empty at a channel boundary, the line carries either zero or a repeat of that channel's previous sample, as the host chooses. A level request tells the host that the queue has fallen below a programmable fill threshold.

Top module: `aud_ser_tx`

## Requirements
- R1: The queue holds DEPTH (8) words. `fifo_full` is high exactly when 8 words are held. A write while full is dropped, and the dropped word is never transmitted.
- R2: `req` is high while the number of held words is strictly below `cfg_thresh`.
- R3: With `cfg_fmt`=0 (I2S), the sample MSB is sent in the second bit clock of a half-frame. Bits after the LSB are zero. For a 32-bit sample, the LSB falls in the first bit clock of the following half-frame.
- R4: With `cfg_fmt`=1 (left-justified; 3 behaves the same), the sample MSB is sent in the first bit clock of the half-frame. Trailing bits are zero.
- R5: With `cfg_fmt`=2 (right-justified), the sample LSB is sent in the 32nd (last) bit clock of the half-frame. Leading bits are zero.
- R6: With `cfg_mode`=0 (stereo), each channel takes its own word: the left word first, then the right word. Each word is masked to its low `cfg_size` bits (8 to 32). Words are taken from the queue only at half-frame starts.
- R7: With `cfg_mode`=1 (mono), one word masked to `cfg_size` bits supplies both channels of a frame.
- R8: With `cfg_mode`=2 (compact 16), bits 15:0 are the left sample and bits 31:16 are the right sample. Both are 16-bit samples, and `cfg_size` has no effect.
- R9: With `cfg_mode`=3 (compact 8), bits 7:0 are the left sample and bits 15:8 are the right sample. Both are 8-bit samples, and bits 31:16 and `cfg_size` have no effect.
- R10: If the queue is empty when a channel needs a word, the channel sends zero when `cfg_zero_uf`=1 and otherwise repeats its previous sample.
- R11: In master mode (`cfg_slave`=0) the bit clock period is 2*HALF_DIV system clocks. Word-select is low for the left half-frame, and each half-frame is 32 bit clocks. Data and word-select change only on falling bit-clock edges.
- R12: In slave mode (`cfg_slave`=1) the data follows external `sck_in`/`ws_in`, and a word-select change restarts the half-frame count. `sck_out` and `ws_out` stay low.
- R13: After reset and while `en` is low, `sck_out`=0, `sd_out`=0, and `ws_out`=1 in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run; low parks the frame at its last bit |
| cfg_slave | input | 1 | 1 = follow external bit clock and word-select |
| cfg_fmt | input | 2 | 0 I2S, 1 left-justified, 2 right-justified |
| cfg_mode | input | 2 | 0 stereo, 1 mono, 2 compact 16, 3 compact 8 |
| cfg_size | input | 6 | Sample width 8..32 for stereo and mono |
| cfg_zero_uf | input | 1 | Underflow action: 1 zero, 0 repeat |
| cfg_thresh | input | 4 | Fill threshold for `req` |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Word written to the queue |
| fifo_full | output | 1 | Queue full |
| req | output | 1 | Fill below threshold |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word-select (slave) |
| sck_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word-select (master) |
| sd_out | output | 1 | Serial data |

## Verification
The hardest situations to reach from the ports are two. The first is a 32-bit I2S sample whose LSB spills into the next half-frame, which can even be the next frame's left half. The second is a dropped write that must leave no trace in the output. The bench reaches both by filling the queue completely before enabling the transmitter. It writes ten words, so two are dropped, and sweeps the sample width up to 32. It then lets the queue run dry, so that the frames which follow show whether the last accepted words, and not the dropped ones, are repeated or replaced by zero.

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int DEPTH    = 8,
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        cfg_slave,
  input  logic [1:0]  cfg_fmt,
  input  logic [1:0]  cfg_mode,
  input  logic [5:0]  cfg_size,
  input  logic        cfg_zero_uf,
  input  logic [$clog2(DEPTH):0] cfg_thresh,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        fifo_full,
  output logic        req,
  input  logic        sck_in,
  input  logic        ws_in,
  output logic        sck_out,
  output logic        ws_out,
  output logic        sd_out
);
  localparam int AW  = $clog2(DEPTH);
  localparam int DVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [31:0]    mem [DEPTH];
  logic [AW-1:0]  wr_p, rd_p;
  logic [AW:0]    count;
  logic [1:0]     sck_sy, ws_sy;
  logic           sck_d, msck, tail;
  logic [DVW-1:0] dcnt;
  logic [5:0]     pos, pos_nx, esz;
  logic [31:0]    smp_l, smp_r, nl, nr, mask, ent, s;
  logic           bit_v;

  wire stereo = cfg_mode == 2'd0;
  wire have   = count != '0;
  wire push   = wr_en && count != FULL;
  wire tick   = dcnt == DVW'(HALF_DIV - 1);
  wire fall   = en && (cfg_slave ? (sck_d && !sck_sy[1]) : (tick && msck));
  wire load_l = fall && pos_nx == 6'd0;
  wire load_r = fall && pos_nx == 6'd32;
  wire pop    = have && (load_l || (load_r && stereo));
  wire [4:0] b = pos[4:0];

  assign pos_nx    = (cfg_slave && ws_sy[1] != pos[5]) ? {ws_sy[1], 5'd0} : pos + 6'd1;
  assign fifo_full = count == FULL;
  assign req       = count < cfg_thresh;
  assign sck_out   = msck;
  assign ws_out    = !cfg_slave && pos[5];
  assign sd_out    = en && bit_v;
  assign ent       = mem[rd_p];
  assign mask      = (esz >= 6'd32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF << esz);
  assign s         = pos[5] ? smp_r : smp_l;

  always_ff @(posedge clk) if (push) mem[wr_p] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0; rd_p <= '0; count <= '0;
    end else begin
      if (push) wr_p <= wr_p + 1'b1;
      if (pop)  rd_p <= rd_p + 1'b1;
      count <= count + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy <= '0; ws_sy <= '0; sck_d <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[0], sck_in};
      ws_sy  <= {ws_sy[0], ws_in};
      sck_d  <= sck_sy[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en || cfg_slave) begin
      dcnt <= '0; msck <= 1'b0;
    end else if (tick) begin
      dcnt <= '0; msck <= ~msck;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) pos <= 6'd63;
    else if (fall)     pos <= pos_nx;
  end

  always_comb begin
    case (cfg_mode)
      2'd2:    begin esz = 6'd16; nl = {16'd0, ent[15:0]}; nr = {16'd0, ent[31:16]}; end
      2'd3:    begin esz = 6'd8;  nl = {24'd0, ent[7:0]};  nr = {24'd0, ent[15:8]};  end
      default: begin esz = cfg_size; nl = ent & mask; nr = ent & mask; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_l <= '0; smp_r <= '0; tail <= 1'b0;
    end else if (load_l) begin
      tail <= smp_r[0];
      if (have) begin
        smp_l <= nl;
        if (!stereo) smp_r <= nr;
      end else if (cfg_zero_uf) begin
        smp_l <= '0;
        if (!stereo) smp_r <= '0;
      end
    end else if (load_r) begin
      tail <= smp_l[0];
      if (stereo && have)             smp_r <= nr;
      else if (stereo && cfg_zero_uf) smp_r <= '0;
    end
  end

  always_comb begin
    bit_v = 1'b0;
    case (cfg_fmt)
      2'd0: if (b == 5'd0)                     bit_v = (esz == 6'd32) && tail;
            else if ({1'b0, b} - 6'd1 < esz)   bit_v = s[5'(esz - {1'b0, b})];
      2'd2: if ({1'b0, b} >= 6'd32 - esz)      bit_v = s[~b];
      default: if ({1'b0, b} < esz)            bit_v = s[5'(esz - 6'd1 - {1'b0, b})];
    endcase
  end
endmodule

module aud_ser_tx_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        cfg_slave,
  input logic        cfg_zero_uf,
  input logic        fifo_full,
  input logic [AW:0] count,
  input logic        fall,
  input logic        load_l,
  input logic [31:0] smp_l,
  input logic        sd_out,
  input logic        ws_out
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  assert_full_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !fall) |=> fifo_full);
  assert_pop_at_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> count >= $past(count));
  assert_ws_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg_slave && !fall) |=> (!en || $stable(ws_out)));
  assert_sd_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fall) |=> (!en || $stable(sd_out)));
  assert_uf_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_l && count == '0 && cfg_zero_uf) |=> smp_l == '0);
  assert_uf_repeat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_l && count == '0 && !cfg_zero_uf) |=> $stable(smp_l));
endmodule

bind aud_ser_tx aud_ser_tx_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cfg_slave(cfg_slave),
  .cfg_zero_uf(cfg_zero_uf), .fifo_full(fifo_full), .count(count),
  .fall(fall), .load_l(load_l), .smp_l(smp_l), .sd_out(sd_out), .ws_out(ws_out)
);

// File: tb/aud_ser_tx_test.sv
`timescale 1ns/1ps
module aud_ser_tx_test;
  localparam int DEPTH = 8, HALF_DIV = 2, SLV_HALF = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, en, cfg_slave, cfg_zero_uf, wr_en, sck_in, ws_in;
  logic [1:0] cfg_fmt, cfg_mode;
  logic [5:0] cfg_size;
  logic [3:0] cfg_thresh;
  logic [31:0] wr_data;
  logic fifo_full, req, sck_out, ws_out, sd_out;

  aud_ser_tx #(.DEPTH(DEPTH), .HALF_DIV(HALF_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_slave(cfg_slave), .cfg_fmt(cfg_fmt),
    .cfg_mode(cfg_mode), .cfg_size(cfg_size), .cfg_zero_uf(cfg_zero_uf),
    .cfg_thresh(cfg_thresh), .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
    .req(req), .sck_in(sck_in), .ws_in(ws_in), .sck_out(sck_out), .ws_out(ws_out),
    .sd_out(sd_out));

  int errors = 0, checks = 0, cfgno = 0;
  logic [31:0] eL [16];
  logic [31:0] eR [16];
  int esz_b, fmt_b, nfr, ndata, per_exp;
  string dtag;
  logic mon_on = 1'b0, slave_run = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input logic [31:0] v, input int n);
    return (n >= 32) ? v : (v & ((32'h1 << n) - 1));
  endfunction

  function automatic logic [31:0] dat(input int k);
    return (32'h9E3779B9 * (k + 1)) ^ (32'h0100_0193 * (cfgno + 3));
  endfunction

  function automatic logic exp_bit(input int f, input int h, input int b);
    logic [31:0] s;
    s = h ? eR[f] : eL[f];
    case (fmt_b)
      0: if (b == 0) return (esz_b == 32) ? (h ? eL[f][0] : (f > 0 ? eR[f-1][0] : 1'b0)) : 1'b0;
         else return (b - 1 < esz_b) ? s[esz_b - b] : 1'b0;
      2: return (b >= 32 - esz_b) ? s[31 - b] : 1'b0;
      default: return (b < esz_b) ? s[esz_b - 1 - b] : 1'b0;
    endcase
  endfunction

  // Receiver model: samples at bench-side rising bit-clock edges
  int fr, bcnt, since, halves;
  logic prev_s, prev_w, started, per_bad;
  logic [31:0] got, expw;
  always @(negedge clk) begin
    logic ms, mw;
    ms = cfg_slave ? sck_in : sck_out;
    mw = cfg_slave ? ws_in : ws_out;
    if (!mon_on) begin
      prev_s = 1'b0; prev_w = 1'b1; fr = -1; bcnt = 0; since = 0;
      started = 1'b0; per_bad = 1'b0; halves = 0;
    end else begin
      since++;
      if (ms && !prev_s) begin
        if (started && since != per_exp) per_bad = 1'b1;
        since = 0;
        if (mw != prev_w) begin
          if (started && bcnt != 31) per_bad = 1'b1;
          bcnt = 0;
          if (!mw) fr++;
          started = 1'b1;
        end else bcnt++;
        prev_w = mw;
        if (fr >= 0 && bcnt < 32) got[31 - bcnt] = sd_out;
        if (fr >= 0 && fr < nfr && bcnt == 31) begin
          for (int k = 0; k < 32; k++) expw[31 - k] = exp_bit(fr, int'(mw), k);
          chk(got == expw, (fr >= ndata) ? {dtag, " R10 underflow"} : dtag, got, expw);
          chk(!per_bad, cfg_slave ? "R12 slave bit timing" : "R11 bit clock/half-frame timing",
              {31'd0, per_bad}, 32'd0);
          halves++;
        end
      end
      prev_s = ms;
    end
  end

  // External bit clock for slave runs
  initial begin
    int cnt = 0, g = 0;
    sck_in = 1'b0; ws_in = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (!slave_run) begin
        cnt = 0; g = 0; sck_in = 1'b0; ws_in = 1'b1;
      end else if (cnt == SLV_HALF - 1) begin
        cnt = 0;
        if (sck_in) begin ws_in = g[5]; g++; end
        sck_in = ~sck_in;
      end else cnt++;
    end
  end

  task automatic run_cfg(input int fmt, input int mode, input int size, input int zuf,
                         input int slv, input int nw, input int nf);
    int n, q;
    logic [31:0] lL, lR, e;
    rst_n = 1'b0; en = 1'b0; mon_on = 1'b0; slave_run = 1'b0; wr_en = 1'b0;
    cfg_fmt = 2'(fmt); cfg_mode = 2'(mode); cfg_size = 6'(size);
    cfg_zero_uf = 1'(zuf); cfg_slave = 1'(slv); cfg_thresh = 4'd3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk({sck_out, ws_out, sd_out, fifo_full, req} == {1'b0, slv == 0, 1'b0, 1'b0, 1'b1},
        "R13 idle outputs", {27'd0, sck_out, ws_out, sd_out, fifo_full, req},
        {27'd0, 1'b0, slv == 0, 1'b0, 1'b0, 1'b1});
    for (int k = 0; k < nw; k++) begin
      wr_en = 1'b1; wr_data = dat(k);
      @(posedge clk); #1;
      wr_en = 1'b0;
      if (k == 2) chk(req == 1'b0, "R2 req at threshold", {31'd0, req}, 32'd0);
    end
    n = (nw > DEPTH) ? DEPTH : nw;
    chk(fifo_full == (n == DEPTH), "R1 full flag", {31'd0, fifo_full}, {31'd0, n == DEPTH});
    chk(req == (n < 3), "R2 req level", {31'd0, req}, {31'd0, n < 3});
    esz_b = (mode == 2) ? 16 : (mode == 3) ? 8 : size;
    fmt_b = fmt; nfr = nf;
    per_exp = slv ? 2 * SLV_HALF : 2 * HALF_DIV;
    ndata = (mode == 0) ? n / 2 : n;
    dtag = $sformatf("%s %s size%0d", fmt == 0 ? "R3 I2S" : fmt == 1 ? "R4 left" : "R5 right",
                     mode == 0 ? "R6 stereo" : mode == 1 ? "R7 mono" :
                     mode == 2 ? "R8 compact16" : "R9 compact8", esz_b);
    if (nw > DEPTH) dtag = {dtag, " R1 drop"};
    if (slv) dtag = {dtag, " R12 slave"};
    q = 0; lL = '0; lR = '0;
    for (int f = 0; f < nf; f++) begin
      if (mode == 0) begin
        eL[f] = (q < n) ? msk(dat(q), size) : (zuf ? 32'd0 : lL); if (q < n) q++;
        eR[f] = (q < n) ? msk(dat(q), size) : (zuf ? 32'd0 : lR); if (q < n) q++;
      end else if (q < n) begin
        e = dat(q); q++;
        case (mode)
          1: begin eL[f] = msk(e, size); eR[f] = msk(e, size); end
          2: begin eL[f] = {16'd0, e[15:0]}; eR[f] = {16'd0, e[31:16]}; end
          default: begin eL[f] = {24'd0, e[7:0]}; eR[f] = {24'd0, e[15:8]}; end
        endcase
      end else begin
        eL[f] = zuf ? 32'd0 : lL; eR[f] = zuf ? 32'd0 : lR;
      end
      lL = eL[f]; lR = eR[f];
    end
    slave_run = 1'(slv); en = 1'b1; mon_on = 1'b1;
    wait (halves >= 2 * nf);
    @(posedge clk); #1;
    if (!slv) chk(1'b1, "R11 run complete", 32'd0, 32'd0);
    mon_on = 1'b0; en = 1'b0; slave_run = 1'b0;
    @(posedge clk); #1;
    chk(sd_out == 1'b0, "R13 data low when disabled", {31'd0, sd_out}, 32'd0);
    cfgno++;
  endtask

  initial begin
    int sizes [4] = '{8, 13, 24, 32};
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_data = '0; cfg_slave = 1'b0;
    cfg_fmt = '0; cfg_mode = '0; cfg_size = 6'd16; cfg_zero_uf = 1'b0; cfg_thresh = 4'd3;
    for (int fm = 0; fm < 3; fm++) begin
      for (int md = 0; md < 2; md++)
        for (int si = 0; si < 4; si++)
          run_cfg(fm, md, sizes[si], (cfgno % 2), 0, md == 0 ? 4 : 2, 4);
      run_cfg(fm, 2, 20, (cfgno % 2), 0, 2, 4);
      run_cfg(fm, 3, 11, (cfgno % 2), 0, 2, 4);
    end
    run_cfg(1, 0, 32, 0, 0, 10, 5);
    run_cfg(0, 0, 32, 1, 0, 10, 5);
    run_cfg(0, 0, 32, 0, 1, 4, 3);
    run_cfg(2, 3, 9, 1, 1, 2, 3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule